// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

The scheduler sits beside the SDRAM access engine. An interval timer sends it a one-cycle refresh tick. It turns each tick into one auto-refresh command on the SDRAM command pins, and it never cuts short a bus cycle that the access engine has started. The scheduler keeps a single pending-refresh bit. A tick that arrives while that bit is already set replaces the earlier request, so the missed refresh is lost. The loss is recorded in a sticky overrun flag.

The access engine starts a new bus cycle only while the grant is high, and it holds busy high until that cycle is complete. Software can also request self-refresh. The scheduler waits for the bus to go idle, precharges all banks and waits a programmable time. It then issues the self-refresh command with CKE falling, and it keeps CKE low and the data bus in high impedance until a release arrives. After release, CKE rises and a programmable number of idle cycles passes before the grant comes back.

Top module: `sdr_refresh_sched`

## Requirements
- R1: In reset and on the first cycle after reset: command pins are NOP ({cs,ras,cas,we} = 0111), cke_o=1, a10_o=0, dq_hiz_o=0, overrun_o=0 and grant_o=1.
- R2: A tick sets the pending bit, and grant_o is low in the cycle that follows the tick. If the bus is idle, the auto-refresh command (0111 → 0001, cke_o high) is driven two cycles after the tick cycle.
- R3: No auto-refresh command is driven in a cycle where bus_busy_i is high. A pending refresh issues on the cycle after the first idle cycle sampled with the bit set.
- R4: At most one refresh is outstanding. A tick that arrives while the bit is set and is not being served in that same cycle yields no extra refresh and sets overrun_o. overrun_o stays high until reset. A tick in the cycle the pending refresh is taken becomes a new request and sets no overrun.
- R5: After each auto-refresh command there are exactly TRC_CYCLES NOP cycles with grant_o low.
- R6: Self-refresh entry drives one precharge cycle (0010) with a10_o=1, then TPW_CYCLES NOP cycles, then one self-refresh command cycle (0001) with cke_o low.
- R7: cke_o stays low, with NOP on the pins, until a release is sampled. dq_hiz_o is high from the precharge cycle through the last exit idle cycle.
- R8: The cycle after a release is sampled, cke_o is high, and grant_o stays low for EXIT_IDLE_CYCLES cycles before the scheduler returns to idle.
- R9: A pending refresh is served before a pending self-refresh request. Ticks are ignored from the cycle that starts self-refresh entry until exit completes. A release outside the held phase has no effect.
- R10: A self-refresh request waits for bus_busy_i to drop before the precharge cycle, and drops grant_o while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| refresh_tick_i | input | 1 | One-cycle refresh request from the interval timer |
| bus_busy_i | input | 1 | Access engine has a bus cycle in progress |
| self_req_i | input | 1 | Self-refresh entry request (pulse) |
| self_release_i | input | 1 | Self-refresh exit request (pulse) |
| grant_o | output | 1 | Access engine may start a new bus cycle |
| cs_no | output | 1 | SDRAM chip select, active low |
| ras_no | output | 1 | SDRAM row strobe, active low |
| cas_no | output | 1 | SDRAM column strobe, active low |
| we_no | output | 1 | SDRAM write enable, active low |
| cke_o | output | 1 | SDRAM clock enable |
| a10_o | output | 1 | Precharge-all address line |
| dq_hiz_o | output | 1 | Data bus must be held in high impedance |
| overrun_o | output | 1 | Sticky flag: a refresh request was lost |

## Verification
A tick shows up as a low grant one cycle later. On an idle bus it shows up as the refresh command two cycles later. A self-refresh request reaches the precharge pins two cycles after it is raised. The precharge wait, the refresh recovery and the exit idle windows then run for exactly their parameter counts, and CKE rises one cycle after a release is sampled. The bench's reference model steps once on every rising edge and uses the same input values the design sees. Every output is compared one delay step after the falling edge, when the registered results are settled and the inputs for the next edge are stable. Dedicated counters also confirm that a busy window with two ticks yields exactly one refresh and one overrun, and that no refresh ever overlaps busy.

// File: rtl/sdr_rs_pkg.sv
package sdr_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_AREF, ST_AREC, ST_PRE, ST_PWAIT, ST_SENTER, ST_SHOLD, ST_SEXIT
  } sched_st_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
  localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
endpackage

// File: rtl/sdr_rs_req_latch.sv
module sdr_rs_req_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic take_i,
  input  logic block_i,
  output logic pend_o,
  output logic overrun_o
);
  logic pend_q, ovr_q, tick_eff;

  assign tick_eff = tick_i & ~block_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      pend_q <= tick_eff | (pend_q & ~take_i);
      // replaced request: earlier one is lost
      if (tick_eff && pend_q && !take_i) ovr_q <= 1'b1;
    end
  end

  assign pend_o    = pend_q;
  assign overrun_o = ovr_q;
endmodule

// File: rtl/sdr_rs_timer.sv
module sdr_rs_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sdr_rs_cmd_enc.sv
module sdr_rs_cmd_enc
  import sdr_rs_pkg::*;
(
  input  sched_st_e st_i,
  output sdr_cmd_t  cmd_o,
  output logic      cke_o,
  output logic      a10_o,
  output logic      hiz_o
);
  always_comb begin
    cmd_o = CMD_NOP;
    cke_o = 1'b1;
    a10_o = 1'b0;
    hiz_o = 1'b0;
    unique case (st_i)
      ST_AREF:   cmd_o = CMD_REF;
      ST_PRE: begin
        cmd_o = CMD_PRE;
        a10_o = 1'b1;
        hiz_o = 1'b1;
      end
      ST_PWAIT:  hiz_o = 1'b1;
      ST_SENTER: begin
        cmd_o = CMD_REF;
        cke_o = 1'b0;
        hiz_o = 1'b1;
      end
      ST_SHOLD: begin
        cke_o = 1'b0;
        hiz_o = 1'b1;
      end
      ST_SEXIT:  hiz_o = 1'b1;
      default:   ;
    endcase
  end
endmodule

// File: rtl/sdr_refresh_sched.sv
module sdr_refresh_sched
  import sdr_rs_pkg::*;
#(
  parameter int unsigned TRC_CYCLES       = 4,
  parameter int unsigned TPW_CYCLES       = 2,
  parameter int unsigned EXIT_IDLE_CYCLES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic refresh_tick_i,
  input  logic bus_busy_i,
  input  logic self_req_i,
  input  logic self_release_i,
  output logic grant_o,
  output logic cs_no,
  output logic ras_no,
  output logic cas_no,
  output logic we_no,
  output logic cke_o,
  output logic a10_o,
  output logic dq_hiz_o,
  output logic overrun_o
);
  localparam int unsigned MAX_A   = (TRC_CYCLES > TPW_CYCLES) ? TRC_CYCLES : TPW_CYCLES;
  localparam int unsigned MAX_CNT = (MAX_A > EXIT_IDLE_CYCLES) ? MAX_A : EXIT_IDLE_CYCLES;
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 1);

  sched_st_e        st_q, st_d;
  logic             pend, take, go_pre, self_seq, sreq_q;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  sdr_cmd_t         cmd;

  assign self_seq = (st_q == ST_PRE) || (st_q == ST_PWAIT) || (st_q == ST_SENTER)
                 || (st_q == ST_SHOLD) || (st_q == ST_SEXIT);

  always_comb begin
    st_d   = st_q;
    take   = 1'b0;
    go_pre = 1'b0;
    unique case (st_q)
      ST_IDLE: if (!bus_busy_i) begin
        if (pend) begin
          st_d = ST_AREF;
          take = 1'b1;
        end else if (sreq_q) begin
          st_d   = ST_PRE;
          go_pre = 1'b1;
        end
      end
      ST_AREF:   st_d = ST_AREC;
      ST_AREC:   if (tmr_last) st_d = ST_IDLE;
      ST_PRE:    st_d = ST_PWAIT;
      ST_PWAIT:  if (tmr_last) st_d = ST_SENTER;
      ST_SENTER: st_d = ST_SHOLD;
      ST_SHOLD:  if (self_release_i) st_d = ST_SEXIT;
      ST_SEXIT:  if (tmr_last) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    if (st_d != st_q) begin
      unique case (st_d)
        ST_AREC:  begin tmr_load = 1'b1; tmr_val = CNT_W'(TRC_CYCLES);       end
        ST_PWAIT: begin tmr_load = 1'b1; tmr_val = CNT_W'(TPW_CYCLES);       end
        ST_SEXIT: begin tmr_load = 1'b1; tmr_val = CNT_W'(EXIT_IDLE_CYCLES); end
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sreq_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sreq_q <= ~self_seq & ~go_pre & (sreq_q | self_req_i);
    end
  end

  sdr_rs_req_latch u_req (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (refresh_tick_i),
    .take_i    (take),
    .block_i   (self_seq | go_pre),
    .pend_o    (pend),
    .overrun_o (overrun_o)
  );

  sdr_rs_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .last_o (tmr_last)
  );

  sdr_rs_cmd_enc u_enc (
    .st_i  (st_q),
    .cmd_o (cmd),
    .cke_o (cke_o),
    .a10_o (a10_o),
    .hiz_o (dq_hiz_o)
  );

  assign cs_no   = cmd.cs_n;
  assign ras_no  = cmd.ras_n;
  assign cas_no  = cmd.cas_n;
  assign we_no   = cmd.we_n;
  assign grant_o = (st_q == ST_IDLE) & ~pend & ~sreq_q;
endmodule

// File: rtl/sdr_refresh_sched_chk.sv
module sdr_refresh_sched_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_busy_i,
  input logic grant_o,
  input logic cs_no,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic cke_o,
  input logic a10_o,
  input logic dq_hiz_o,
  input logic overrun_o
);
  logic is_ref, is_pre, is_nop;
  assign is_ref = !cs_no && !ras_no && !cas_no && we_no;
  assign is_pre = !cs_no && !ras_no && cas_no && !we_no;
  assign is_nop = !cs_no && ras_no && cas_no && we_no;

  assert_no_ref_when_busy_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && cke_o) |-> !bus_busy_i);

  assert_recovery_nop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_ref && cke_o) |=> (is_nop && !grant_o));

  assert_pre_all_banks_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_pre |-> (a10_o && dq_hiz_o));

  assert_cke_fall_on_self_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cke_o) |-> is_ref);

  assert_hiz_in_self_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (dq_hiz_o && !grant_o));

  assert_exit_no_grant_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> (!grant_o && is_nop));

  assert_overrun_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

bind sdr_refresh_sched sdr_refresh_sched_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_busy_i (bus_busy_i),
  .grant_o    (grant_o),
  .cs_no      (cs_no),
  .ras_no     (ras_no),
  .cas_no     (cas_no),
  .we_no      (we_no),
  .cke_o      (cke_o),
  .a10_o      (a10_o),
  .dq_hiz_o   (dq_hiz_o),
  .overrun_o  (overrun_o)
);

// File: tb/sdr_refresh_sched_tb_top.sv
module sdr_refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TRC  = 4;
  localparam int TPW  = 2;
  localparam int EXIT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, busy = 1'b0, sreq = 1'b0, srel = 1'b0;
  logic grant, cs_n, ras_n, cas_n, we_n, cke, a10, hiz, ovr;

  int checks = 0, fails = 0;
  int ref_seen = 0, overlap = 0;

  // reference model state
  int   m_mode = 0, m_rem = 0;
  bit   m_pend = 0, m_sreq = 0, m_ovr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdr_refresh_sched #(.TRC_CYCLES(TRC), .TPW_CYCLES(TPW), .EXIT_IDLE_CYCLES(EXIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .refresh_tick_i(tick), .bus_busy_i(busy),
    .self_req_i(sreq), .self_release_i(srel), .grant_o(grant),
    .cs_no(cs_n), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n),
    .cke_o(cke), .a10_o(a10), .dq_hiz_o(hiz), .overrun_o(ovr)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_pend = 0; m_sreq = 0; m_ovr = 0;
    end else begin
      bit take, gopre, inself, teff;
      int nm;
      take = 0; gopre = 0; nm = m_mode;
      case (m_mode)
        0: if (!busy) begin
             if (m_pend) begin nm = 1; take = 1; end
             else if (m_sreq) begin nm = 3; gopre = 1; end
           end
        1: begin nm = 2; m_rem = TRC; end
        2: if (m_rem == 1) nm = 0; else m_rem--;
        3: begin nm = 4; m_rem = TPW; end
        4: if (m_rem == 1) nm = 5; else m_rem--;
        5: nm = 6;
        6: if (srel) begin nm = 7; m_rem = EXIT; end
        default: if (m_rem == 1) nm = 0; else m_rem--;
      endcase
      inself = (m_mode >= 3);
      teff   = tick && !inself && !gopre;
      if (teff && m_pend && !take) m_ovr = 1;
      m_pend = teff || (m_pend && !take);
      m_sreq = !inself && !gopre && (m_sreq || sreq);
      m_mode = nm;
    end
  end

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle compare, after inputs settle
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      int ecmd;
      string creq;
      ecmd = (m_mode == 1 || m_mode == 5) ? 1 : (m_mode == 3) ? 2 : 7;
      creq = (m_mode == 1) ? "R2" : (m_mode >= 3) ? "R6" : "R5";
      chk(creq, {cs_n, ras_n, cas_n, we_n}, ecmd);
      chk("R7", cke, !(m_mode == 5 || m_mode == 6));
      chk("R6", a10, m_mode == 3);
      chk("R7", hiz, m_mode >= 3);
      chk("R8", grant, (m_mode == 0) && !m_pend && !m_sreq);
      chk("R4", ovr, m_ovr);
      if ({cs_n, ras_n, cas_n, we_n} == 4'b0001 && cke) begin
        ref_seen++;
        if (busy) overlap++;
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tick();
    tick = 1'b1; cyc(1); tick = 1'b0;
  endtask

  // access engine: start only on grant, hold busy for len cycles
  task automatic access(input int len);
    while (!grant) cyc(1);
    busy = 1'b1; cyc(len); busy = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    cyc(2);
    chk("R1", {cs_n, ras_n, cas_n, we_n, cke, a10, hiz, ovr}, 8'b0111_1000);
    rst_n = 1'b1;
    cyc(1);
    #1;
    chk("R1", grant, 1);

    // R2: single tick on idle bus, refresh two cycles after tick cycle
    base = ref_seen;
    tick = 1'b1; cyc(1); tick = 1'b0;
    #1; chk("R2", grant, 0);
    cyc(1); #1; chk("R2", {cs_n, ras_n, cas_n, we_n}, 4'b0001);
    cyc(TRC + 2);
    chk("R2", ref_seen - base, 1);

    // R3/R4: two ticks inside one busy window -> one refresh, one overrun
    base = ref_seen;
    fork
      access(12);
      begin cyc(2); pulse_tick(); cyc(3); pulse_tick(); end
    join
    cyc(TRC + 4);
    chk("R4", ref_seen - base, 1);
    chk("R4", ovr, 1);

    // R3: tick during a long busy, refresh waits
    base = ref_seen;
    fork
      access(20);
      begin cyc(1); pulse_tick(); end
    join
    chk("R3", ref_seen - base, 0);
    cyc(TRC + 4);
    chk("R3", ref_seen - base, 1);

    // R9: release outside held phase ignored; refresh before self entry
    srel = 1'b1; cyc(1); srel = 1'b0;
    cyc(2);
    base = ref_seen;
    tick = 1'b1; sreq = 1'b1; cyc(1); tick = 1'b0; sreq = 1'b0;
    cyc(TRC + 3 + TPW + 1);
    chk("R9", ref_seen - base, 1);
    chk("R6", cke, 0);
    // R9: ticks in self-refresh ignored
    base = ref_seen;
    cyc(5); pulse_tick(); cyc(5); pulse_tick(); cyc(5);
    chk("R7", cke, 0);
    srel = 1'b1; cyc(1); srel = 1'b0;
    cyc(EXIT + 3);
    chk("R9", ref_seen - base, 0);
    chk("R8", grant, 1);

    // R10: self request while busy waits for idle
    fork
      access(8);
      begin cyc(2); sreq = 1'b1; cyc(1); sreq = 1'b0; end
    join
    cyc(1 + TPW + 2);
    chk("R10", cke, 0);
    cyc(4);
    srel = 1'b1; cyc(1); srel = 1'b0;
    cyc(EXIT + 2);

    // R4: tick coinciding with take -> new request, no new overrun change
    base = ref_seen;
    tick = 1'b1; cyc(1); tick = 1'b1; cyc(1); tick = 1'b0;
    cyc(2 * (TRC + 3));
    chk("R4", ref_seen - base, 2);

    chk("R3", overlap, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule